// File: doc/BRIEF.md
# Two-Grid Fluorescent Display Scanner

This block time-multiplexes a vacuum fluorescent display across two grid lines. A free-running frame counter, advanced by an oscillator-rate clock enable, splits every frame into two equal phases. In the first phase grid 0 is lit and the 41 segment lines show the low half of an 82-bit display word. In the second phase grid 1 is lit and the segments show the high half. A 10-bit brightness code shortens the lit part of each phase. A short dark gap at the start of each phase keeps one grid's pattern from bleeding into the other.

The display word and the brightness code are copied into frame-local shadow registers only when a new frame starts. A frame therefore never mixes old and new content, whatever the host does to the inputs mid-frame. A blank input and a non-zero sleep code both stop the scan. They hold the counter at zero and drive every output off. While stopped, the shadow registers track the inputs, so the next frame starts with current data.

All outputs are registered logic-level enables. The high-voltage drivers and the oscillator are outside the block.

Top module: `vfd_duplex_scan`

## Requirements
- R1: At most one grid enable is high in any cycle. `grid_en[0]` may be high only in the first half of the frame (counts 0 to 2047). `grid_en[1]` may be high only in the second half (counts 2048 to 4095).
- R2: The frame counter advances by one on each clock cycle in which `osc_en` is high. A frame spans 4096 such cycles, and in cycles with `osc_en` low the counter holds.
- R3: While `grid_en[0]` is high, `seg_en[i]` equals `disp_data[i]` of the frame's shadow copy for i = 0 to 40. A 1 lights the segment.
- R4: While `grid_en[1]` is high, `seg_en[i]` equals `disp_data[41+i]` of the frame's shadow copy for i = 0 to 40.
- R5: In the first 16 counts of each phase (phase position 0 to 15), both grids and all segments are off.
- R6: With phase position p and shadow brightness code D, the grid of the current phase is lit exactly when p >= 16 and p - 16 < 2*D. D = 0 keeps the display dark, and all segments are off whenever no grid is lit.
- R7: A clock edge that samples `blank` high leaves every output off and the counter at zero. After release, scanning restarts from count 0.
- R8: A clock edge that samples a non-zero `sleep_mode` leaves every output off and the counter held at zero.
- R9: Changes to `disp_data` and `dim_code` during a running frame have no effect until the counter wraps to the start of the next frame. While the scan is stopped by blank or sleep, the shadow copies follow the inputs.
- R10: After `rst_n` is asserted, all grid and segment enables are off, the counter is zero, and the shadow copies are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator-rate advance strobe for the frame counter |
| blank | input | 1 | Active-high forced blank; stops and clears the scan |
| sleep_mode | input | 2 | Power-down code; any non-zero value stops the scan |
| disp_data | input | 82 | Segment pattern, bits 0..40 for grid 0 and 41..81 for grid 1 |
| dim_code | input | 10 | Brightness code; lit span per phase is twice this value in counts |
| grid_en | output | 2 | Grid enables, one per multiplexed digit line |
| seg_en | output | 41 | Segment enables, 1 = lit |

## Verification
The bench concentrates on the edges of the lit window. It checks the last dark gap count and the first lit one in each phase, and the lit span at both the largest and a small brightness code. An off-by-one in the gap or the limit shifts the lit span by one count, which the per-cycle comparison shows at once. It also changes the display word and brightness code mid-frame. A design that bypassed its shadow copies would change the segments in the very next cycle. It stretches `osc_en` to one cycle in three, where a counter that ignored the strobe would change phase three times too early. Blank and sleep are applied mid-frame. A design that only masked the outputs, and did not restart the counter, would relight mid-phase after release.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

    typedef enum logic {
        SCAN_HALT = 1'b0,
        SCAN_LIVE = 1'b1
    } scan_mode_e;

    // number of bits needed to select one of n grids (at least one)
    function automatic int sel_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vfd_timebase.sv
module vfd_timebase
    import vfd_scan_pkg::*;
#(
    parameter int GRIDS   = 2,
    parameter int PHASE_W = 11,
    localparam int SEL_W  = sel_bits(GRIDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt,
    input  logic               osc_en,
    output logic [SEL_W-1:0]   sel_d,
    output logic [PHASE_W-1:0] pos_d,
    output logic [SEL_W-1:0]   sel_q,
    output logic [PHASE_W-1:0] pos_q,
    output logic               load_o,
    output logic               live_o
);

    localparam logic [SEL_W-1:0]   LAST_SEL = SEL_W'(GRIDS - 1);
    localparam logic [PHASE_W-1:0] LAST_POS = '1;

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic [PHASE_W-1:0] pos;
    } tb_state_t;

    tb_state_t  st_d, st_q;
    logic       load_d;
    scan_mode_e mode_d;

    always_comb begin
        st_d   = st_q;
        load_d = 1'b0;
        mode_d = SCAN_LIVE;
        if (halt) begin
            st_d   = '0;
            load_d = 1'b1;
            mode_d = SCAN_HALT;
        end else if (osc_en) begin
            if (st_q.pos == LAST_POS) begin
                st_d.pos = '0;
                if (st_q.sel == LAST_SEL) begin
                    st_d.sel = '0;
                    load_d   = 1'b1;
                end else begin
                    st_d.sel = st_q.sel + 1'b1;
                end
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_d  = st_d.sel;
    assign pos_d  = st_d.pos;
    assign sel_q  = st_q.sel;
    assign pos_q  = st_q.pos;
    assign load_o = load_d;
    assign live_o = (mode_d == SCAN_LIVE);

    assert_hold_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (st_q == '0));

    assert_wait_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !osc_en) |=> $stable(st_q));

    assert_sel_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sel <= LAST_SEL);

endmodule

// File: rtl/vfd_frame_latch.sv
module vfd_frame_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout_d,
    output logic [W-1:0] dout_q
);

    typedef struct packed {
        logic [W-1:0] val;
    } fl_state_t;

    fl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) st_d.val = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout_d = st_d.val;
    assign dout_q = st_q.val;

    assert_frame_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.val));

endmodule

// File: rtl/vfd_drive.sv
module vfd_drive
    import vfd_scan_pkg::*;
#(
    parameter int SEGS    = 41,
    parameter int GRIDS   = 2,
    parameter int PHASE_W = 11,
    parameter int DIM_W   = 10,
    parameter int GAP     = 16,
    localparam int SEL_W  = sel_bits(GRIDS),
    localparam int SHIFT  = PHASE_W - DIM_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  live_d,
    input  logic [SEL_W-1:0]      sel_d,
    input  logic [PHASE_W-1:0]    pos_d,
    input  logic [GRIDS*SEGS-1:0] disp_d,
    input  logic [DIM_W-1:0]      dim_d,
    output logic [GRIDS-1:0]      grid_q,
    output logic [SEGS-1:0]       seg_q
);

    localparam logic [PHASE_W-1:0] GAP_V = PHASE_W'(GAP);

    typedef struct packed {
        logic [GRIDS-1:0] grid;
        logic [SEGS-1:0]  seg;
    } dr_state_t;

    dr_state_t st_d, st_q;

    logic [SEGS-1:0]    bank [GRIDS];
    logic [PHASE_W-1:0] lim;
    logic [PHASE_W-1:0] rel;
    logic               lit;

    for (genvar g = 0; g < GRIDS; g++) begin : g_bank
        assign bank[g] = disp_d[g*SEGS +: SEGS];
    end

    always_comb begin
        lim = PHASE_W'(dim_d) << SHIFT;
        rel = pos_d - GAP_V;
        lit = live_d && (pos_d >= GAP_V) && (rel < lim);
        st_d = '0;
        if (lit) begin
            st_d.grid = GRIDS'(1) << sel_d;
            st_d.seg  = bank[sel_d];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grid_q = st_q.grid;
    assign seg_q  = st_q.seg;

    assert_one_grid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.grid));

    assert_gap_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_d < GAP_V) |=> (st_q.grid == '0 && st_q.seg == '0));

    assert_seg_needs_grid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.grid == '0) |-> (st_q.seg == '0));

    assert_dim_zero_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dim_d == '0) |=> (st_q.grid == '0));

endmodule

// File: rtl/vfd_duplex_scan.sv
module vfd_duplex_scan
    import vfd_scan_pkg::*;
#(
    parameter int SEGS    = 41,
    parameter int GRIDS   = 2,
    parameter int PHASE_W = 11,
    parameter int DIM_W   = 10,
    parameter int SLEEP_W = 2,
    parameter int GAP     = 16,
    localparam int SEL_W  = sel_bits(GRIDS),
    localparam int DISP_W = GRIDS * SEGS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               osc_en,
    input  logic               blank,
    input  logic [SLEEP_W-1:0] sleep_mode,
    input  logic [DISP_W-1:0]  disp_data,
    input  logic [DIM_W-1:0]   dim_code,
    output logic [GRIDS-1:0]   grid_en,
    output logic [SEGS-1:0]    seg_en
);

    logic               halt;
    logic [SEL_W-1:0]   sel_d, sel_q;
    logic [PHASE_W-1:0] pos_d, pos_q;
    logic               load, live;
    logic [DISP_W-1:0]  disp_d, disp_q;
    logic [DIM_W-1:0]   dim_d, dim_q;

    assign halt = blank || (sleep_mode != '0);

    vfd_timebase #(.GRIDS(GRIDS), .PHASE_W(PHASE_W)) u_time (
        .clk    (clk),
        .rst_n  (rst_n),
        .halt   (halt),
        .osc_en (osc_en),
        .sel_d  (sel_d),
        .pos_d  (pos_d),
        .sel_q  (sel_q),
        .pos_q  (pos_q),
        .load_o (load),
        .live_o (live)
    );

    vfd_frame_latch #(.W(DISP_W)) u_disp_sh (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .din    (disp_data),
        .dout_d (disp_d),
        .dout_q (disp_q)
    );

    vfd_frame_latch #(.W(DIM_W)) u_dim_sh (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .din    (dim_code),
        .dout_d (dim_d),
        .dout_q (dim_q)
    );

    vfd_drive #(
        .SEGS(SEGS), .GRIDS(GRIDS), .PHASE_W(PHASE_W),
        .DIM_W(DIM_W), .GAP(GAP)
    ) u_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .live_d (live),
        .sel_d  (sel_d),
        .pos_d  (pos_d),
        .disp_d (disp_d),
        .dim_d  (dim_d),
        .grid_q (grid_en),
        .seg_q  (seg_en)
    );

    assert_blank_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (grid_en == '0 && seg_en == '0 && pos_q == '0 && sel_q == '0));

    assert_sleep_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_mode != '0) |=> (grid_en == '0 && seg_en == '0));

    assert_grid_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (grid_en != '0) |-> (grid_en == (GRIDS'(1) << sel_q)));

    assert_shadow_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q != '0) |-> ($stable(disp_q) && $stable(dim_q)));

endmodule

// File: tb/tb_vfd_duplex_scan.sv
module tb_vfd_duplex_scan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_en = 1'b0;
    logic        blank = 1'b0;
    logic [1:0]  sleep_mode = 2'b00;
    logic [81:0] disp_data = '0;
    logic [9:0]  dim_code = '0;
    logic [1:0]  grid_en;
    logic [40:0] seg_en;

    int total = 0;
    int bad = 0;
    string sect = "R10";

    // reference model state
    int          m_cnt = 0;
    logic [81:0] m_disp = '0;
    int          m_dim = 0;
    logic [1:0]  e_grid = '0;
    logic [40:0] e_seg = '0;
    int          lit_cycles = 0;
    int          both_cycles = 0;

    always #10 clk = ~clk;

    vfd_duplex_scan dut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .blank(blank),
        .sleep_mode(sleep_mode), .disp_data(disp_data), .dim_code(dim_code),
        .grid_en(grid_en), .seg_en(seg_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [81:0] act, input logic [81:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int  pos;
        int  ph;
        bit  run;
        bit  on;
        string tag;
        run = rst_n && !blank && (sleep_mode == 2'b00);
        if (!rst_n) begin
            m_cnt = 0; m_disp = '0; m_dim = 0;
        end else if (!run) begin
            m_cnt = 0; m_disp = disp_data; m_dim = int'(dim_code);
        end else if (osc_en) begin
            m_cnt = (m_cnt + 1) % 4096;
            if (m_cnt == 0) begin
                m_disp = disp_data; m_dim = int'(dim_code);
            end
        end
        pos = m_cnt % 2048;
        ph  = m_cnt / 2048;
        on  = run && (pos >= 16) && ((pos - 16) < 2 * m_dim);
        e_grid = on ? (ph == 1 ? 2'b10 : 2'b01) : 2'b00;
        e_seg  = on ? (ph == 1 ? m_disp[81:41] : m_disp[40:0]) : '0;
        #2;
        if (grid_en != 2'b00) lit_cycles++;
        if (grid_en == 2'b11) both_cycles++;
        if (!run)           tag = "R7/R8/R10";
        else if (pos < 16)  tag = "R5";
        else if (ph == 0)   tag = "R3/R6";
        else                tag = "R4/R6";
        check(grid_en == e_grid, {sect, " ", tag, "/R1"}, "grid",
              82'(grid_en), 82'(e_grid));
        check(seg_en == e_seg, {sect, " ", tag}, "seg",
              82'(seg_en), 82'(e_seg));
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [81:0] pat_a;
        logic [81:0] pat_b;
        pat_a = {41'h0AA_5555_3C3C, 41'h155_0F0F_A5A5};
        pat_b = {41'h1FF_0000_FFFF, 41'h003_F0F0_1234};

        // R10: reset state
        cycles(3);
        check(grid_en == 2'b00 && seg_en == '0, "R10", "reset outputs",
              82'({grid_en, seg_en}), 82'(0));
        disp_data = pat_a;
        dim_code  = 10'd1023;
        osc_en    = 1'b1;
        rst_n     = 1'b1;
        cycles(1);
        check(grid_en == 2'b00 && seg_en == '0, "R10", "first frame count",
              82'({grid_en, seg_en}), 82'(0));

        // full brightness, one frame plus (R1 R3 R4 R5 R6)
        sect = "R3/R4";
        cycles(4200);

        // R9: mid-frame change of data and dimmer
        sect = "R9";
        while (m_cnt != 100) cycles(1);
        disp_data = pat_b;
        dim_code  = 10'd100;
        cycles(1);
        check(seg_en == pat_a[40:0], "R9", "old pattern kept mid-frame",
              82'(seg_en), 82'(pat_a[40:0]));
        while (m_cnt != 0) cycles(1);
        cycles(2100);
        lit_cycles = 0;
        cycles(4096);
        check(lit_cycles == 400, "R6", "lit count dim=100",
              82'(lit_cycles), 82'(400));

        // R6: dimmer zero stays dark
        sect = "R6";
        dim_code = 10'd0;
        while (m_cnt != 0) cycles(1);
        cycles(2);
        lit_cycles = 0;
        cycles(4096);
        check(lit_cycles == 0, "R6", "dim zero dark", 82'(lit_cycles), 82'(0));

        // R2: slow strobe
        sect = "R2";
        dim_code = 10'd7;
        while (m_cnt != 0) cycles(1);
        for (int k = 0; k < 14000; k++) begin
            osc_en = (k % 3 == 0);
            cycles(1);
        end
        check(m_cnt != 0, "R2", "slow strobe not yet wrapped twice",
              82'(m_cnt), 82'(1));
        osc_en = 1'b1;
        dim_code = 10'd1023;
        disp_data = pat_a;
        cycles(5000);

        // R7: blank mid-frame
        sect = "R7";
        while (m_cnt != 2500) cycles(1);
        blank = 1'b1;
        cycles(1);
        check(grid_en == 2'b00 && seg_en == '0, "R7", "blank dark",
              82'({grid_en, seg_en}), 82'(0));
        cycles(40);
        blank = 1'b0;
        cycles(17);
        check(grid_en == 2'b01 && seg_en == pat_a[40:0], "R7",
              "restart at grid 0 after gap",
              82'({grid_en, seg_en}), 82'({2'b01, pat_a[40:0]}));
        cycles(300);

        // R8: sleep
        sect = "R8";
        sleep_mode = 2'b10;
        cycles(1);
        check(grid_en == 2'b00 && seg_en == '0, "R8", "sleep dark",
              82'({grid_en, seg_en}), 82'(0));
        cycles(100);
        check(grid_en == 2'b00 && seg_en == '0, "R8", "sleep still dark",
              82'({grid_en, seg_en}), 82'(0));
        sleep_mode = 2'b00;
        disp_data = pat_b;
        cycles(4200);

        check(both_cycles == 0, "R1", "never two grids",
              82'(both_cycles), 82'(0));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule